// File: doc/BRIEF.md
# Secure key slot store

This block holds a bank of secret keys for a crypto engine. It has 32 slots of 256 bits each. There are two ways in. The first is a 32-bit register port on which every request carries a secure/non-secure attribute. The second is a wide fetch port: the engine names a slot by index and receives all 256 bits of it one cycle later.

Two 32-bit masks, each with one bit per slot, control access. The non-secure mask decides which slots a non-secure register access may reach. The engine-use mask decides which slots the engine may fetch. Only secure accesses can read or write either mask. A blocked register access reads zero, drops its write and returns an error flag. A blocked fetch returns zeros and raises a denied flag.

On the register port, slot N occupies a 0x40-byte window starting at N*0x40. Only the first 32 bytes of that window hold key material. The slot windows together fill 0x000 to 0x7FF, so the two mask registers sit just above them.

Top module: `keyslot_store`

## Requirements
- R1: After reset the non-secure mask is 0x200000FF, the engine-use mask is 0xFFFFFFFF, every key word is zero, and rvalid_o, err_o, eng_valid_o and eng_denied_o are low.
- R2: A request on the register port is answered exactly one cycle later with rvalid_o high. A read returns the addressed word, and a write updates it and answers with rdata_o zero. Key word k (k = 0..7) of slot N sits at byte address N*0x40 + 4k. When rvalid_o is low, rdata_o and err_o are zero.
- R3: A secure access reaches every slot, whatever the non-secure mask holds.
- R4: A non-secure access to a slot whose non-secure mask bit is 0 returns rdata_o zero and err_o high, and its write is dropped.
- R5: The non-secure mask is at byte address 0x800 and the engine-use mask is at 0x804. Bit N of each refers to slot N. A secure access reads and writes them.
- R6: A non-secure access to either mask register reads zero, drops its write and sets err_o.
- R7: Bytes 0x20 to 0x3F of each slot window read as zero and ignore writes. err_o is set there only under the R4 condition.
- R8: Addresses from 0x808 upward read zero, ignore writes and never set err_o.
- R9: A fetch request is answered one cycle later with eng_valid_o high. eng_key_o carries the slot's eight key words, with word k in bits [32k+31:32k].
- R10: A fetch of a slot whose engine-use bit is 0 returns eng_key_o all zeros, with eng_denied_o high in the same cycle as eng_valid_o.
- R11: When a fetch and a register write fall in the same cycle, the fetch returns the key contents and engine-use mask as they stood before that write.
- R12: The non-secure mask has no effect on fetches, and the engine-use mask has no effect on the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Register write enable |
| sec_i | input | 1 | Access is secure |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Register response valid |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Access blocked by security rules |
| eng_req_i | input | 1 | Engine fetch request |
| eng_slot_i | input | 5 | Slot index to fetch |
| eng_valid_o | output | 1 | Fetch response valid |
| eng_key_o | output | 256 | Fetched key |
| eng_denied_o | output | 1 | Fetch refused by the engine-use mask |

## Verification
A register write and an engine fetch can land on the same clock edge. The bench drives that collision deliberately in three forms: a secure key write and a fetch of the same slot, a secure write to the engine-use mask that clears the fetched slot's bit, and long randomized runs in which both ports are active at once. The behavioural model always computes the fetch result from its state before applying the write. Each collision is judged on two cycles: the colliding fetch must return the old value, and the fetch that follows must return the new one.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
  typedef enum logic [2:0] {
    ACC_KEY,
    ACC_PAD,
    ACC_NS_MASK,
    ACC_ENG_MASK,
    ACC_NONE
  } acc_kind_e;
endpackage

// File: rtl/keyslot_decode.sv
module keyslot_decode
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int KEY_BITS  = 256,
  parameter int DATA_W    = 32,
  parameter int STRIDE_B  = 64,
  parameter int ADDR_W    = 12,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int WORD_W    = $clog2(KEY_BITS / DATA_W)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int STRIDE_LG = $clog2(STRIDE_B);
  localparam int BYTE_LG   = $clog2(DATA_W / 8);
  localparam int KEY_BYTES = KEY_BITS / 8;
  localparam int MASK_BASE = NUM_SLOTS * STRIDE_B;
  localparam int WA_W      = ADDR_W - BYTE_LG;

  logic [STRIDE_LG-1:0] off;
  logic [WA_W-1:0]      waddr;

  assign off   = addr_i[STRIDE_LG-1:0];
  assign waddr = addr_i[ADDR_W-1:BYTE_LG];

  always_comb begin
    slot_o = addr_i[STRIDE_LG +: SLOT_W];
    word_o = off[BYTE_LG +: WORD_W];
    if (addr_i < ADDR_W'(MASK_BASE)) begin
      kind_o = (off < STRIDE_LG'(KEY_BYTES)) ? ACC_KEY : ACC_PAD;
    end else if (waddr == WA_W'(MASK_BASE / (DATA_W / 8))) begin
      kind_o = ACC_NS_MASK;
    end else if (waddr == WA_W'(MASK_BASE / (DATA_W / 8) + 1)) begin
      kind_o = ACC_ENG_MASK;
    end else begin
      kind_o = ACC_NONE;
    end
  end
endmodule

// File: rtl/keyslot_masks.sv
module keyslot_masks #(
  parameter int                   NUM_SLOTS = 32,
  parameter logic [NUM_SLOTS-1:0] NS_RST    = 32'h200000FF,
  parameter logic [NUM_SLOTS-1:0] ENG_RST   = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ns_we_i,
  input  logic                 eng_we_i,
  input  logic [NUM_SLOTS-1:0] wdata_i,
  output logic [NUM_SLOTS-1:0] ns_mask_o,
  output logic [NUM_SLOTS-1:0] eng_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_mask_o  <= NS_RST;
      eng_mask_o <= ENG_RST;
    end else begin
      if (ns_we_i)  ns_mask_o  <= wdata_i;
      if (eng_we_i) eng_mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/keyslot_array.sv
module keyslot_array #(
  parameter int NUM_SLOTS = 32,
  parameter int KEY_BITS  = 256,
  parameter int DATA_W    = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int WORD_W    = $clog2(KEY_BITS / DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SLOT_W-1:0]   wslot_i,
  input  logic [WORD_W-1:0]   wword_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [SLOT_W-1:0]   rslot_i,
  input  logic [WORD_W-1:0]   rword_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [SLOT_W-1:0]   eslot_i,
  output logic [KEY_BITS-1:0] ekey_o
);
  logic [KEY_BITS-1:0] slot_view [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [KEY_BITS-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (we_i && wslot_i == SLOT_W'(s)) begin
        q[int'(wword_i) * DATA_W +: DATA_W] <= wdata_i;
      end
    end
    assign slot_view[s] = q;
  end

  assign rdata_o = slot_view[rslot_i][int'(rword_i) * DATA_W +: DATA_W];
  assign ekey_o  = slot_view[eslot_i];
endmodule

// File: rtl/keyslot_store.sv
module keyslot_store
  import keyslot_pkg::*;
#(
  parameter int                   NUM_SLOTS   = 32,
  parameter int                   KEY_BITS    = 256,
  parameter int                   DATA_W      = 32,
  parameter int                   STRIDE_B    = 64,
  parameter logic [NUM_SLOTS-1:0] NS_MASK_RST = 32'h200000FF,
  parameter logic [NUM_SLOTS-1:0] ENG_MASK_RST = '1,
  parameter int                   ADDR_W      = $clog2(NUM_SLOTS * STRIDE_B) + 1,
  parameter int                   SLOT_W      = $clog2(NUM_SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                sec_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                err_o,
  input  logic                eng_req_i,
  input  logic [SLOT_W-1:0]   eng_slot_i,
  output logic                eng_valid_o,
  output logic [KEY_BITS-1:0] eng_key_o,
  output logic                eng_denied_o
);
  localparam int WORD_W = $clog2(KEY_BITS / DATA_W);

  acc_kind_e           kind;
  logic [SLOT_W-1:0]   slot;
  logic [WORD_W-1:0]   word;
  logic [NUM_SLOTS-1:0] ns_mask, eng_mask;
  logic [DATA_W-1:0]   arr_rdata, rd_next;
  logic [KEY_BITS-1:0] arr_ekey;
  logic                slot_ok, blocked, key_we, ns_we, eng_we, eng_ok;

  keyslot_decode #(
    .NUM_SLOTS(NUM_SLOTS), .KEY_BITS(KEY_BITS), .DATA_W(DATA_W),
    .STRIDE_B(STRIDE_B), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)
  ) u_decode (
    .addr_i(addr_i), .kind_o(kind), .slot_o(slot), .word_o(word)
  );

  // slot permission applies to the whole stride, padding included
  assign slot_ok = sec_i || ns_mask[slot];
  always_comb begin
    unique case (kind)
      ACC_KEY, ACC_PAD:          blocked = !slot_ok;
      ACC_NS_MASK, ACC_ENG_MASK: blocked = !sec_i;
      default:                   blocked = 1'b0;
    endcase
  end

  assign key_we = req_i && we_i && kind == ACC_KEY && slot_ok;
  assign ns_we  = req_i && we_i && sec_i && kind == ACC_NS_MASK;
  assign eng_we = req_i && we_i && sec_i && kind == ACC_ENG_MASK;

  keyslot_masks #(
    .NUM_SLOTS(NUM_SLOTS), .NS_RST(NS_MASK_RST), .ENG_RST(ENG_MASK_RST)
  ) u_masks (
    .clk_i(clk_i), .rst_ni(rst_ni), .ns_we_i(ns_we), .eng_we_i(eng_we),
    .wdata_i(wdata_i[NUM_SLOTS-1:0]), .ns_mask_o(ns_mask), .eng_mask_o(eng_mask)
  );

  keyslot_array #(
    .NUM_SLOTS(NUM_SLOTS), .KEY_BITS(KEY_BITS), .DATA_W(DATA_W),
    .SLOT_W(SLOT_W), .WORD_W(WORD_W)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(key_we), .wslot_i(slot),
    .wword_i(word), .wdata_i(wdata_i), .rslot_i(slot), .rword_i(word),
    .rdata_o(arr_rdata), .eslot_i(eng_slot_i), .ekey_o(arr_ekey)
  );

  always_comb begin
    rd_next = '0;
    if (req_i && !we_i && !blocked) begin
      unique case (kind)
        ACC_KEY:      rd_next = arr_rdata;
        ACC_NS_MASK:  rd_next = DATA_W'(ns_mask);
        ACC_ENG_MASK: rd_next = DATA_W'(eng_mask);
        default:      rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= req_i;
      rdata_o  <= rd_next;
      err_o    <= req_i && blocked;
    end
  end

  // fetch samples pre-edge state, so a colliding write is not yet visible
  assign eng_ok = eng_mask[eng_slot_i];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_valid_o  <= 1'b0;
      eng_key_o    <= '0;
      eng_denied_o <= 1'b0;
    end else begin
      eng_valid_o  <= eng_req_i;
      eng_key_o    <= (eng_req_i && eng_ok) ? arr_ekey : '0;
      eng_denied_o <= eng_req_i && !eng_ok;
    end
  end
endmodule

// File: rtl/keyslot_store_sva.sv
module keyslot_store_sva #(
  parameter int NUM_SLOTS = 32,
  parameter int KEY_BITS  = 256,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int SLOT_W    = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic                 sec_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 rvalid_o,
  input logic [DATA_W-1:0]    rdata_o,
  input logic                 err_o,
  input logic                 eng_req_i,
  input logic [SLOT_W-1:0]    eng_slot_i,
  input logic                 eng_valid_o,
  input logic [KEY_BITS-1:0]  eng_key_o,
  input logic                 eng_denied_o,
  input logic [NUM_SLOTS-1:0] ns_mask,
  input logic [NUM_SLOTS-1:0] eng_mask
);
  assert_resp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  assert_no_resp_without_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0 && !err_o));
  assert_err_only_nonsecure_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sec_i) |=> !err_o);
  assert_err_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  assert_ns_write_keeps_masks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !sec_i) |=> ($stable(ns_mask) && $stable(eng_mask)));
  assert_masks_need_secure_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && sec_i) |=> ($stable(ns_mask) && $stable(eng_mask)));
  assert_fetch_answered_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_i |=> eng_valid_o);
  assert_denied_with_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_denied_o |-> (eng_valid_o && eng_key_o == '0));
  assert_denied_follows_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_i |=> (eng_denied_o == !$past(eng_mask[eng_slot_i])));
  assert_unmapped_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i >= ADDR_W'(NUM_SLOTS * 64 + 8)) |=> (!err_o && rdata_o == '0));
endmodule

bind keyslot_store keyslot_store_sva #(
  .NUM_SLOTS(NUM_SLOTS), .KEY_BITS(KEY_BITS), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) sva_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .sec_i(sec_i),
  .addr_i(addr_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o),
  .eng_req_i(eng_req_i), .eng_slot_i(eng_slot_i), .eng_valid_o(eng_valid_o),
  .eng_key_o(eng_key_o), .eng_denied_o(eng_denied_o),
  .ns_mask(ns_mask), .eng_mask(eng_mask)
);

// File: tb/keyslot_store_tb_top.sv
`timescale 1ns/1ps
module keyslot_store_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         rvalid, err, eng_req = 1'b0, eng_valid, eng_denied;
  logic [31:0]  rdata;
  logic [4:0]   eng_slot = '0;
  logic [255:0] eng_key;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_key [32][8];
  logic [31:0] m_ns, m_eng;

  always #4 clk = ~clk;

  keyslot_store dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .sec_i(sec),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .err_o(err), .eng_req_i(eng_req), .eng_slot_i(eng_slot),
    .eng_valid_o(eng_valid), .eng_key_o(eng_key), .eng_denied_o(eng_denied)
  );

  task automatic step(input logic rq, input logic w, input logic s,
                      input logic [11:0] a, input logic [31:0] d,
                      input logic erq, input logic [4:0] ei, input string tag);
    logic         e_rv, e_err, e_ev, e_den, ok;
    logic [31:0]  e_rd;
    logic [255:0] e_key;
    logic [4:0]   sl;
    req = rq; we = w; sec = s; addr = a; wdata = d; eng_req = erq; eng_slot = ei;
    // engine result from state before any same-cycle write (R11)
    e_ev = erq; e_den = erq && !m_eng[ei]; e_key = '0;
    if (erq && m_eng[ei]) for (int k = 0; k < 8; k++) e_key[32*k +: 32] = m_key[ei][k];
    e_rv = rq; e_rd = '0; e_err = 1'b0;
    if (rq) begin
      if (a < 12'h800) begin
        sl = a[10:6]; ok = s || m_ns[sl]; e_err = !ok;
        if (ok && !a[5]) begin
          if (w) m_key[sl][a[4:2]] = d; else e_rd = m_key[sl][a[4:2]];
        end
      end else if (a[11:2] == 10'h200 || a[11:2] == 10'h201) begin
        if (!s) e_err = 1'b1;
        else if (!a[2]) begin if (w) m_ns = d; else e_rd = m_ns; end
        else begin if (w) m_eng = d; else e_rd = m_eng; end
      end
    end
    @(posedge clk); @(negedge clk);
    checks++;
    if (rvalid !== e_rv || rdata !== e_rd || err !== e_err ||
        eng_valid !== e_ev || eng_denied !== e_den || eng_key !== e_key) begin
      fails++;
      $display("FAIL %s: got rv=%0b rd=%h err=%0b ev=%0b den=%0b key=%h exp rv=%0b rd=%h err=%0b ev=%0b den=%0b key=%h",
               tag, rvalid, rdata, err, eng_valid, eng_denied, eng_key,
               e_rv, e_rd, e_err, e_ev, e_den, e_key);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic s, input string tag);
    step(1'b1, 1'b1, s, a, d, 1'b0, 5'd0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input logic s, input string tag);
    step(1'b1, 1'b0, s, a, 32'h0, 1'b0, 5'd0, tag);
  endtask
  task automatic fetch(input logic [4:0] i, input string tag);
    step(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, i, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 32; s++) for (int k = 0; k < 8; k++) m_key[s][k] = '0;
    m_ns = 32'h200000FF; m_eng = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    checks++;
    if (rvalid !== 1'b0 || err !== 1'b0 || eng_valid !== 1'b0 || eng_denied !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs in reset: got rv=%0b err=%0b ev=%0b den=%0b exp 0", rvalid, err, eng_valid, eng_denied);
    end
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 5'd0, "R1 idle");
    rd(12'h800, 1'b1, "R1 ns mask reset");
    rd(12'h804, 1'b1, "R1 eng mask reset");
    rd(12'h7C4, 1'b1, "R1 key zero");
    fetch(5'd31, "R1 fetch zero");
    // secure fills, including slots non-secure cannot reach (R3)
    for (int k = 0; k < 8; k++) begin
      wr(12'h000 + 12'(4*k), 32'hA0000000 + 32'(k), 1'b1, "R2 fill slot0");
      wr(12'h200 + 12'(4*k), 32'hB8000000 + 32'(k), 1'b1, "R3 fill slot8");
      wr(12'h740 + 12'(4*k), 32'hD1D00000 + 32'(k), 1'b1, "R2 fill slot29");
      wr(12'h7C0 + 12'(4*k), 32'hF1F00000 + 32'(k), 1'b1, "R3 fill slot31");
    end
    rd(12'h20C, 1'b1, "R3 secure read slot8");
    rd(12'h7DC, 1'b1, "R3 secure read slot31");
    rd(12'h01C, 1'b0, "R2 ns read slot0");
    rd(12'h204, 1'b0, "R4 ns read slot8");
    wr(12'h204, 32'hDEAD0000, 1'b0, "R4 ns write slot8");
    rd(12'h204, 1'b1, "R4 slot8 unchanged");
    wr(12'h748, 32'h12345678, 1'b0, "R2 ns write slot29");
    rd(12'h748, 1'b0, "R2 ns readback slot29");
    wr(12'h020, 32'hFFFFFFFF, 1'b1, "R7 pad write");
    rd(12'h020, 1'b1, "R7 pad read");
    rd(12'h03C, 1'b0, "R7 pad ns allowed");
    rd(12'h000, 1'b1, "R7 word0 intact");
    rd(12'h220, 1'b0, "R7 pad ns denied slot");
    wr(12'h808, 32'h55555555, 1'b1, "R8 unmapped write");
    rd(12'h808, 1'b1, "R8 unmapped read");
    rd(12'hFFC, 1'b0, "R8 unmapped ns read");
    rd(12'h800, 1'b0, "R6 ns read ns mask");
    rd(12'h804, 1'b0, "R6 ns read eng mask");
    wr(12'h800, 32'hFFFFFFFF, 1'b0, "R6 ns write ns mask");
    wr(12'h804, 32'h0, 1'b0, "R6 ns write eng mask");
    rd(12'h800, 1'b1, "R6 ns mask intact");
    rd(12'h804, 1'b1, "R6 eng mask intact");
    fetch(5'd8, "R12 fetch ns-blocked slot");
    fetch(5'd0, "R9 fetch slot0");
    fetch(5'd31, "R9 fetch slot31");
    wr(12'h804, 32'hFFFFFEFF, 1'b1, "R5 write eng mask");
    rd(12'h804, 1'b1, "R5 read eng mask");
    fetch(5'd8, "R10 fetch denied");
    rd(12'h208, 1'b1, "R12 reg port ignores eng mask");
    wr(12'h800, 32'h200001FF, 1'b1, "R5 open slot8");
    rd(12'h208, 1'b0, "R5 ns read slot8 opened");
    // collisions (R11)
    step(1'b1, 1'b1, 1'b1, 12'h00C, 32'hCAFEF00D, 1'b1, 5'd0, "R11 key write vs fetch");
    fetch(5'd0, "R11 fetch after write");
    step(1'b1, 1'b1, 1'b1, 12'h804, 32'hFFFFFEFE, 1'b1, 5'd0, "R11 mask write vs fetch");
    fetch(5'd0, "R11 fetch after mask clear");
    step(1'b1, 1'b0, 1'b0, 12'h744, 32'h0, 1'b1, 5'd29, "R9 both ports read");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) a = {10'h200, 1'b0, r[4]};
      else if (r[3:0] == 4'd1) a = 12'h800 + {r[9:2], 2'b00};
      else a = {1'b0, r[10:6], r[15:12], 2'b00};
      if (a[11:2] == 10'h200 && r[20]) a[1:0] = 2'b00;
      step(r[16], r[17], r[18] | r[19], a, $urandom, r[21], r[26:22], "R11 mixed traffic");
    end
    step(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 5'd0, "R2 final idle");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule